// File: doc/BRIEF.md
# Precomputation-Gated Unsigned Comparator

This block registers two unsigned operands and reports whether the first is strictly greater than the second, while cutting switching activity in its operand registers. Each operand is split into its top bit and the remaining lower bits. The top bits always enter the register stage. From them, a small predictor works out two flags: "first operand wins" (top bit of A set, top bit of B clear) and "second operand wins" (the reverse). When either flag is set, the top bits alone decide the answer. The lower-bit register then keeps its previous contents, so its flops and the lower comparator see no toggles. When the top bits match, the lower bits are loaded and compared.

Operands arrive on a valid/ready stream, and the result leaves on a second valid/ready stream with a single register stage between them. An input transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output holds no result, or the result is being taken in that same cycle. This gives one result per cycle under full flow and no loss under back-pressure. A held result and its valid flag stay unchanged until `out_ready` is seen high. A saturating counter reports how many accepted transfers left the lower register frozen.

Top module: `precomp_gt_cmp`

## Requirements
- R1: For each accepted operand pair, `out_valid` is high from the next rising edge on, and `out_gt` is 1 exactly when `in_a` > `in_b` as unsigned numbers.
- R2: When the top bits (bit WIDTH-1) of the operands differ, `out_gt` equals the top bit of `in_a`, whatever the lower bits hold.
- R3: `hold_count` rises by one for each accepted transfer whose top bits differ. It is unchanged by other cycles and saturates at its all-ones value.
- R4: During and after reset, and until a transfer is accepted, `out_valid` is 0, `hold_count` is 0 and `in_ready` is 1.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_gt` stay unchanged on the next cycle.
- R6: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. With `in_ready` low, an offered pair is not taken.
- R7: With `in_valid` and `out_ready` held high, one result is produced every cycle.
- R8: Equal operands give `out_gt` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | WIDTH | First operand, unsigned |
| in_b | input | WIDTH | Second operand, unsigned |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_gt | output | 1 | 1 when first operand exceeds second |
| hold_count | output | CNT_W | Saturating count of transfers with a frozen lower register |

## Verification
The properties assume that `in_a` and `in_b` are known and stable across each edge where a transfer is offered. They also assume that `out_ready` never carries X once reset is released. The stimulus meets this by driving every input on the falling edge, one full half-period away from the sampling edge. The stimulus draws operands at random, with half the pairs forced to share a top bit so that both the frozen and the loading paths are exercised often. It also randomizes `in_valid` and `out_ready`, so that stalls, with a new pair offered against a full stage, appear throughout the run.

// File: rtl/precomp_pkg.sv
package precomp_pkg;

  // Decision flags derived from the always-registered top bits.
  typedef struct packed {
    logic a_wins;  // top of A set, top of B clear
    logic b_wins;  // top of B set, top of A clear
  } pred_t;

endpackage

// File: rtl/precomp_predictor.sv
module precomp_predictor
  import precomp_pkg::*;
(
  input  logic  a_top,
  input  logic  b_top,
  output pred_t pred,
  output logic  freeze
);

  always_comb begin
    pred.a_wins = a_top & ~b_top;
    pred.b_wins = ~a_top & b_top;
    freeze      = pred.a_wins | pred.b_wins;
  end

endmodule

// File: rtl/precomp_low_reg.sv
module precomp_low_reg #(
  parameter int LO_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LO_W-1:0] d_a,
  input  logic [LO_W-1:0] d_b,
  output logic [LO_W-1:0] q_a,
  output logic [LO_W-1:0] q_b
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_a <= '0;
      q_b <= '0;
    end else if (load) begin
      q_a <= d_a;
      q_b <= d_b;
    end
  end

endmodule

// File: rtl/precomp_resolve.sv
module precomp_resolve
  import precomp_pkg::*;
#(
  parameter int LO_W = 15
) (
  input  pred_t           pred,
  input  logic [LO_W-1:0] lo_a,
  input  logic [LO_W-1:0] lo_b,
  output logic            gt
);

  logic lo_gt;

  // Scan from the top lower bit down; the first differing bit decides.
  always_comb begin
    logic decided;
    decided = 1'b0;
    lo_gt   = 1'b0;
    for (int i = LO_W - 1; i >= 0; i--) begin
      if (!decided && (lo_a[i] != lo_b[i])) begin
        decided = 1'b1;
        lo_gt   = lo_a[i];
      end
    end
  end

  always_comb begin
    if (pred.a_wins)      gt = 1'b1;
    else if (pred.b_wins) gt = 1'b0;
    else                  gt = lo_gt;
  end

endmodule

// File: rtl/precomp_hold_ctr.sv
module precomp_hold_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (bump && count != TOP) count <= count + 1'b1;
  end

endmodule

// File: rtl/precomp_gt_cmp.sv
module precomp_gt_cmp
  import precomp_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_gt,
  output logic [CNT_W-1:0] hold_count
);

  localparam int LO_W = WIDTH - 1;
  localparam int TOP  = WIDTH - 1;

  pred_t           pred_d, pred_q;
  logic            freeze;
  logic            take;
  logic            vld_q;
  logic [LO_W-1:0] lo_a_q, lo_b_q;

  assign in_ready  = !vld_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = vld_q;

  precomp_predictor pred_i (
    .a_top  (in_a[TOP]),
    .b_top  (in_b[TOP]),
    .pred   (pred_d),
    .freeze (freeze)
  );

  // Always-loaded group: the decision flags from the top bits.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (take) pred_q <= pred_d;
      if (take)           vld_q <= 1'b1;
      else if (out_ready) vld_q <= 1'b0;
    end
  end

  // Gated group: lower bits load only when the top bits tie.
  precomp_low_reg #(.LO_W(LO_W)) low_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (take && !freeze),
    .d_a   (in_a[LO_W-1:0]),
    .d_b   (in_b[LO_W-1:0]),
    .q_a   (lo_a_q),
    .q_b   (lo_b_q)
  );

  precomp_resolve #(.LO_W(LO_W)) res_i (
    .pred (pred_q),
    .lo_a (lo_a_q),
    .lo_b (lo_b_q),
    .gt   (out_gt)
  );

  precomp_hold_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (take && freeze),
    .count (hold_count)
  );

endmodule

// File: rtl/precomp_gt_cmp_chk.sv
module precomp_gt_cmp_chk #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_gt,
  input logic [CNT_W-1:0] hold_count
);

  logic acc;
  logic split;
  assign acc   = in_valid && in_ready;
  assign split = in_a[WIDTH-1] != in_b[WIDTH-1];

  // R1
  result_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_valid && (out_gt == ($past(in_a) > $past(in_b)))));

  // R2
  top_decides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && split) |=> (out_gt == $past(in_a[WIDTH-1])));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && split && hold_count != {CNT_W{1'b1}}) |=>
      (hold_count == CNT_W'($past(hold_count) + 1'b1)));

  // R3
  count_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && split) |=> $stable(hold_count));

  // R5
  stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_gt)));

  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  equal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_a == in_b) |=> !out_gt);

endmodule

bind precomp_gt_cmp precomp_gt_cmp_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_a       (in_a),
  .in_b       (in_b),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_gt     (out_gt),
  .hold_count (hold_count)
);

// File: tb/precomp_gt_cmp_tb_top.sv
module precomp_gt_cmp_tb_top;

  localparam int W  = 8;
  localparam int CW = 4;
  localparam logic [CW-1:0] CMAX = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic          out_gt;
  logic [CW-1:0] hold_count;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // bench model
  logic          exp_vld = 1'b0;
  logic          exp_gt  = 1'b0;
  logic [CW-1:0] exp_cnt = '0;
  string         gt_tag  = "R1";

  always #2.5 clk = ~clk;  // 200 MHz

  precomp_gt_cmp #(.WIDTH(W), .CNT_W(CW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_gt     (out_gt),
    .hold_count (hold_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ref_gt(input logic [W-1:0] a, input logic [W-1:0] b);
    return a > b;
  endfunction

  // Called at a falling edge: drive, check ready, advance one cycle, check outputs.
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic r);
    logic exp_rdy;
    logic acc;
    in_valid = v; in_a = a; in_b = b; out_ready = r;
    #1;
    exp_rdy = !exp_vld || r;
    chk(in_ready == exp_rdy, "R6", in_ready, exp_rdy);
    acc = v && exp_rdy;
    if (acc) begin
      exp_vld = 1'b1;
      exp_gt  = ref_gt(a, b);
      if (a[W-1] != b[W-1]) begin
        gt_tag = "R2";
        if (exp_cnt != CMAX) exp_cnt = exp_cnt + 1'b1;
      end else if (a == b) gt_tag = "R8";
      else                 gt_tag = "R1";
    end else if (r) begin
      exp_vld = 1'b0;
    end else if (exp_vld) begin
      gt_tag = "R5";
    end
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == exp_vld, "R1", out_valid, exp_vld);
    if (exp_vld) chk(out_gt == exp_gt, gt_tag, out_gt, exp_gt);
    chk(hold_count == exp_cnt, "R3", hold_count, exp_cnt);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int nb;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R4: reset state while reset is held
    chk(out_valid == 1'b0, "R4", out_valid, 0);
    chk(hold_count == '0, "R4", hold_count, 0);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R4", out_valid, 0);
    chk(in_ready == 1'b1, "R4", in_ready, 1);
    @(negedge clk);
    chk(hold_count == '0, "R4", hold_count, 0);

    // directed corners: top bits decide with opposing lower bits (R2)
    step(1'b1, 8'h80, 8'h7F, 1'b1);
    step(1'b1, 8'h7F, 8'h80, 1'b1);
    step(1'b1, 8'hFF, 8'h00, 1'b1);
    step(1'b1, 8'h00, 8'hFF, 1'b1);
    // tied top bits: lower compare (R1) and equality (R8)
    step(1'b1, 8'h12, 8'h11, 1'b1);
    step(1'b1, 8'h11, 8'h12, 1'b1);
    step(1'b1, 8'h55, 8'h55, 1'b1);
    step(1'b1, 8'hFF, 8'hFF, 1'b1);
    step(1'b1, 8'h00, 8'h00, 1'b1);
    // frozen lower register, then tie needing fresh lower bits
    step(1'b1, 8'h81, 8'h7E, 1'b1);
    step(1'b1, 8'h03, 8'h04, 1'b1);
    // back-pressure: R5 stall and R6 refusal of a new pair
    step(1'b1, 8'h90, 8'h10, 1'b0);
    step(1'b1, 8'h01, 8'h02, 1'b0);
    step(1'b1, 8'h01, 8'h02, 1'b0);
    step(1'b0, 8'h00, 8'h00, 1'b1);

    // R7: full-rate burst
    nb = 0;
    for (int i = 0; i < 20; i++) begin
      step(1'b1, W'($urandom), W'($urandom), 1'b1);
      if (out_valid) nb++;
    end
    chk(nb == 20, "R7", nb, 20);
    step(1'b0, 8'h00, 8'h00, 1'b1);

    // R3: drive the counter into saturation
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = W'($urandom);
      b = W'($urandom);
      b[W-1] = ~a[W-1];
      step(1'b1, a, b, 1'b1);
    end
    chk(hold_count == CMAX, "R3", hold_count, CMAX);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = W'($urandom);
      b = W'($urandom);
      if ($urandom % 2 == 0) b[W-1] = a[W-1];
      if ($urandom % 16 == 0) b = a;
      step(($urandom % 4) != 0, a, b, ($urandom % 3) != 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule